// File: doc/BRIEF.md
# Two-Level Hierarchical Segment Addresser

This block turns an N-bit operand into a flat address for the coefficient table of a piecewise polynomial function approximator. The operand interval is first cut into outer segments, chosen by the top V0 bits of the operand. Each outer segment is then cut uniformly into 2^v1 inner segments. The inner bit count v1 is set separately for every outer segment, so steep regions of the function can get fine segments and flat regions coarse ones. The outer level is one of four variants, picked by parameter:
- uniform;
- power-of-two, refined toward both ends of the interval;
- power-of-two, refined toward the low end only;
- power-of-two, refined toward the high end only.

A constant parameter table holds v1 for each outer segment. The start of each outer segment's block in the flat table is the running sum of 2^v1 over the outer segments before it. The address is that start plus the inner index. The operand bits below the inner field are returned left-aligned in an N-1 bit field, where a polynomial datapath can use them as the interpolation offset. An optional output register adds one cycle of latency.

Top module: `hsa_addresser`

## Requirements
- R1: In the uniform variant, the outer segment index is operand bits [N-1:N-V0] and the inner field is the v1 bits just below them.
- R2: In the both-ends variant (2*V0 outer segments), let r be the length of the leading run of equal bits in the top V0 bits. When the top bit is 0, the index is 0 if r = V0, otherwise V0-r. When the top bit is 1, the index is 2*V0-1 if r = V0, otherwise V0+r-1.
- R3: In every power-of-two variant, the inner field starts directly below the first operand bit that differs from the top bit. If the whole top V0 field is one run, it starts below that field, at bit N-V0-1. With the defaults, x = 0x300 gives address 5, x = 0x7FF gives address 13 and x = 0xDFF gives address 18.
- R4: In the low-end variant (V0+1 segments), z is the number of leading zeros in the top field when the top bit is 0, and 0 otherwise. The index is V0-z.
- R5: In the high-end variant (V0+1 segments), the index is the number of leading ones in the top field, which is 0 when the top bit is 0.
- R6: The address equals the sum of 2^v1 over all lower outer segments plus the inner index. v1 for segment j is INNER_BITS[4j+3:4j].
- R7: With k leftover bits below the inner field, frac_o holds operand bits [k-1:0] in its top k positions and zeros below. When k = 0, frac_o is zero.
- R8: The address is always below the table total. Operand 0 maps to address 0 with zero offset, and the all-ones operand maps to the last address.
- R9: Addresses never decrease as the operand increases. Within one address, a larger operand gives a larger offset.
- R10: With REG_OUT = 1, the outputs follow the operand one clock later and are zero while rst_n is low. With REG_OUT = 0, they follow the operand in the same cycle and reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_i | input | N | Operand |
| addr_o | output | ADDR_W | Flat coefficient-table address |
| frac_o | output | N-1 | Leftover low operand bits, left-aligned |

## Verification
The bench sweeps every operand through all four outer variants and goes after the points where the sliding inner field moves. These are the first and last outer segments of the both-ends variant, the middle pair around the top-bit flip, and segments whose v1 is zero.

A design that placed the inner field one bit off would return addresses that skip or repeat. It would also show offsets whose low bits are not zero where they should be. An error in the running base sum would show up as a gap or an overlap between neighbouring outer segments, which the ordering check detects. Holding the old value for exactly one clock, and clearing it under reset, catches a register stage that is missing or doubled.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

   typedef enum logic [1:0] {
      HSA_UNIFORM    = 2'd0,
      HSA_POW2_BOTH  = 2'd1,
      HSA_POW2_LOW   = 2'd2,
      HSA_POW2_HIGH  = 2'd3
   } hsa_scheme_e;

   // number of outer segments produced by a given variant
   function automatic int unsigned seg_count(hsa_scheme_e sch, int unsigned v0);
      case (sch)
         HSA_UNIFORM:   return 32'd1 << v0;
         HSA_POW2_BOTH: return 2 * v0;
         default:       return v0 + 1;
      endcase
   endfunction

endpackage

// File: rtl/hsa_run_detect.sv
// Length of the leading run of bits equal to the top bit.
module hsa_run_detect #(
   parameter int unsigned W     = 3,
   parameter int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     bits_i,
   output logic [CNT_W-1:0] run_o
);

   always_comb begin
      logic same;
      same  = 1'b1;
      run_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         same  = same & (bits_i[i] == bits_i[W-1]);
         run_o = run_o + CNT_W'(same);
      end
   end

endmodule

// File: rtl/hsa_outer_classify.sv
// Outer segment index and number of operand bits below the outer boundary.
module hsa_outer_classify
   import hsa_pkg::*;
#(
   parameter int unsigned  N      = 12,
   parameter int unsigned  V0     = 3,
   parameter hsa_scheme_e  SCHEME = HSA_POW2_BOTH,
   parameter int unsigned  SEG_W  = 3,
   parameter int unsigned  REM_W  = $clog2(N + 1)
) (
   input  logic [V0-1:0]    outer_i,
   output logic [SEG_W-1:0] seg_o,
   output logic [REM_W-1:0] rem_o
);

   localparam int unsigned RUN_W = $clog2(V0 + 1);

   generate
      if (SCHEME == HSA_UNIFORM) begin : g_uni
         assign seg_o = SEG_W'(outer_i);
         assign rem_o = REM_W'(N - V0);
      end else begin : g_pow2
         logic [RUN_W-1:0] run;
         logic             msb;

         hsa_run_detect #(.W(V0), .CNT_W(RUN_W)) u_run (
            .bits_i (outer_i),
            .run_o  (run)
         );

         assign msb = outer_i[V0-1];

         if (SCHEME == HSA_POW2_BOTH) begin : g_both
            always_comb begin
               int r;
               int clamp;
               r     = int'(run);
               clamp = (r == int'(V0)) ? int'(V0) - 1 : r;
               rem_o = REM_W'(int'(N) - 1 - clamp);
               if (!msb)
                  seg_o = (r == int'(V0)) ? '0 : SEG_W'(int'(V0) - r);
               else
                  seg_o = (r == int'(V0)) ? SEG_W'(2 * V0 - 1)
                                          : SEG_W'(int'(V0) + r - 1);
            end
         end else if (SCHEME == HSA_POW2_LOW) begin : g_low
            always_comb begin
               int z;
               int clamp;
               z     = msb ? 0 : int'(run);
               clamp = (z == int'(V0)) ? int'(V0) - 1 : z;
               rem_o = REM_W'(int'(N) - 1 - clamp);
               seg_o = SEG_W'(int'(V0) - z);
            end
         end else begin : g_high
            always_comb begin
               int o;
               int clamp;
               o     = msb ? int'(run) : 0;
               clamp = (o == int'(V0)) ? int'(V0) - 1 : o;
               rem_o = REM_W'(int'(N) - 1 - clamp);
               seg_o = SEG_W'(o);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hsa_seg_table.sv
// Constant per-outer-segment inner bit count and table base.
module hsa_seg_table #(
   parameter int unsigned NSEG      = 6,
   parameter int unsigned SEG_W     = 3,
   parameter int unsigned V1_FW     = 4,
   parameter int unsigned TAB_SLOTS = 16,
   parameter logic [TAB_SLOTS*V1_FW-1:0] INNER_BITS = '0,
   parameter int unsigned MAX_V1    = 9,
   parameter int unsigned V1_W      = $clog2(MAX_V1 + 1),
   parameter int unsigned ADDR_W    = 6
) (
   input  logic [SEG_W-1:0]  seg_i,
   output logic [V1_W-1:0]   v1_o,
   output logic [ADDR_W-1:0] base_o
);

   localparam int unsigned ROWS = 1 << SEG_W;

   function automatic int unsigned v1_of(int unsigned idx);
      return int'(INNER_BITS[idx*V1_FW +: V1_FW]);
   endfunction

   function automatic longint unsigned base_of(int unsigned idx);
      longint unsigned acc;
      acc = 0;
      for (int unsigned k = 0; k < idx; k++) acc += longint'(1) << v1_of(k);
      return acc;
   endfunction

   localparam longint unsigned TOTAL = base_of(NSEG);

   if (NSEG > TAB_SLOTS) begin : g_err_slots
      $fatal(1, "hsa_seg_table: more outer segments than table slots");
   end
   if (TOTAL > (longint'(1) << ADDR_W)) begin : g_err_addr
      $fatal(1, "hsa_seg_table: ADDR_W too small for the table total");
   end

   logic [V1_W-1:0]   v1_rom   [ROWS];
   logic [ADDR_W-1:0] base_rom [ROWS];

   generate
      for (genvar g = 0; g < ROWS; g++) begin : g_row
         if (g < NSEG) begin : g_used
            if (v1_of(g) > MAX_V1) begin : g_err_v1
               $fatal(1, "hsa_seg_table: inner bit count exceeds N-V0");
            end
            assign v1_rom[g]   = V1_W'(v1_of(g));
            assign base_rom[g] = ADDR_W'(base_of(g));
         end else begin : g_pad
            assign v1_rom[g]   = '0;
            assign base_rom[g] = '0;
         end
      end
   endgenerate

   assign v1_o   = v1_rom[seg_i];
   assign base_o = base_rom[seg_i];

endmodule

// File: rtl/hsa_inner_extract.sv
// Pulls the inner index out of a sliding field and left-aligns the leftover bits.
module hsa_inner_extract #(
   parameter int unsigned N     = 12,
   parameter int unsigned REM_W = $clog2(N + 1),
   parameter int unsigned V1_W  = 4,
   parameter int unsigned IDX_W = 9,
   parameter int unsigned OFF_W = N - 1
) (
   input  logic [N-1:0]     x_i,
   input  logic [REM_W-1:0] rem_i,
   input  logic [V1_W-1:0]  v1_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [OFF_W-1:0] frac_o
);

   always_comb begin
      logic [REM_W-1:0] keep;
      logic [N-1:0]     shifted;
      logic [N-1:0]     mask;
      logic [N-1:0]     lifted;
      keep    = rem_i - REM_W'(v1_i);
      shifted = x_i >> keep;
      mask    = ~({N{1'b1}} << v1_i);
      idx_o   = IDX_W'(shifted & mask);
      lifted  = x_i << (int'(N) - int'(keep));
      frac_o  = lifted[N-1 -: OFF_W];
   end

endmodule

// File: rtl/hsa_addresser.sv
module hsa_addresser
   import hsa_pkg::*;
#(
   parameter int unsigned N          = 12,
   parameter int unsigned V0         = 3,
   parameter hsa_scheme_e SCHEME     = HSA_POW2_BOTH,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned V1_FW      = 4,
   parameter int unsigned TAB_SLOTS  = 16,
   parameter logic [TAB_SLOTS*V1_FW-1:0] INNER_BITS = 64'h2222_2222_2242_0312,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      x_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [N-2:0]      frac_o
);

   localparam int unsigned NSEG   = seg_count(SCHEME, V0);
   localparam int unsigned SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1;
   localparam int unsigned REM_W  = $clog2(N + 1);
   localparam int unsigned MAX_V1 = N - V0;
   localparam int unsigned V1_W   = $clog2(MAX_V1 + 1);
   localparam int unsigned IDX_W  = (MAX_V1 > 0) ? MAX_V1 : 1;
   localparam int unsigned OFF_W  = N - 1;

   if (V0 < 1 || V0 >= N) begin : g_err_v0
      $fatal(1, "hsa_addresser: V0 must lie in 1..N-1");
   end
   if (SCHEME != HSA_UNIFORM && V0 < 2) begin : g_err_pow2
      $fatal(1, "hsa_addresser: power-of-two variants need V0 >= 2");
   end

   logic [SEG_W-1:0]  seg;
   logic [REM_W-1:0]  rem;
   logic [V1_W-1:0]   v1;
   logic [ADDR_W-1:0] base;
   logic [IDX_W-1:0]  idx;
   logic [OFF_W-1:0]  frac_c;
   logic [ADDR_W-1:0] addr_c;

   hsa_outer_classify #(
      .N(N), .V0(V0), .SCHEME(SCHEME), .SEG_W(SEG_W), .REM_W(REM_W)
   ) u_outer (
      .outer_i (x_i[N-1 -: V0]),
      .seg_o   (seg),
      .rem_o   (rem)
   );

   hsa_seg_table #(
      .NSEG(NSEG), .SEG_W(SEG_W), .V1_FW(V1_FW), .TAB_SLOTS(TAB_SLOTS),
      .INNER_BITS(INNER_BITS), .MAX_V1(MAX_V1), .V1_W(V1_W), .ADDR_W(ADDR_W)
   ) u_table (
      .seg_i  (seg),
      .v1_o   (v1),
      .base_o (base)
   );

   hsa_inner_extract #(
      .N(N), .REM_W(REM_W), .V1_W(V1_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) u_inner (
      .x_i    (x_i),
      .rem_i  (rem),
      .v1_i   (v1),
      .idx_o  (idx),
      .frac_o (frac_c)
   );

   assign addr_c = base + ADDR_W'(idx);

   generate
      if (REG_OUT) begin : g_reg
         logic [ADDR_W-1:0] addr_q;
         logic [OFF_W-1:0]  frac_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               frac_q <= '0;
            end else begin
               addr_q <= addr_c;
               frac_q <= frac_c;
            end
         end
         assign addr_o = addr_q;
         assign frac_o = frac_q;
      end else begin : g_comb
         wire unused_clk = ^{clk, rst_n};
         assign addr_o = addr_c;
         assign frac_o = frac_c;
      end
   endgenerate

endmodule

// File: rtl/hsa_addresser_chk.sv
module hsa_addresser_chk
   import hsa_pkg::*;
#(
   parameter int unsigned N          = 12,
   parameter int unsigned V0         = 3,
   parameter hsa_scheme_e SCHEME     = HSA_POW2_BOTH,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned V1_FW      = 4,
   parameter int unsigned TAB_SLOTS  = 16,
   parameter logic [TAB_SLOTS*V1_FW-1:0] INNER_BITS = '0,
   parameter bit          REG_OUT    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      x_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [N-2:0]      frac_o
);

   function automatic longint unsigned table_total();
      longint unsigned acc;
      acc = 0;
      for (int unsigned k = 0; k < seg_count(SCHEME, V0); k++)
         acc += longint'(1) << int'(INNER_BITS[k*V1_FW +: V1_FW]);
      return acc;
   endfunction

   localparam longint unsigned TOTAL = table_total();
   localparam logic [ADDR_W:0] LAST  = (ADDR_W+1)'(TOTAL - 1);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(TOTAL);
   localparam int unsigned     LAT   = REG_OUT ? 1 : 0;

   logic [1:0]   cnt;
   logic [N-1:0] x_q;
   logic [N-1:0] xs;
   logic         ready1;
   logic         ready2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         x_q <= '0;
      end else begin
         if (cnt != 2'd3) cnt <= cnt + 2'd1;
         x_q <= x_i;
      end
   end

   assign xs     = REG_OUT ? x_q : x_i;
   assign ready1 = int'(cnt) >= int'(LAT);
   assign ready2 = int'(cnt) >= int'(LAT) + 1;

   // R8
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, addr_o} < LIMIT);

   // R8
   zero_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready1 && xs == '0) |-> (addr_o == '0 && frac_o == '0));

   // R8
   ones_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready1 && xs == '1) |-> ({1'b0, addr_o} == LAST));

   // R9
   addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready2 && xs > $past(xs)) |-> (addr_o >= $past(addr_o)));

   // R9
   frac_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready2 && xs > $past(xs) && addr_o == $past(addr_o))
         |-> (frac_o > $past(frac_o)));

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready2 && xs == $past(xs)) |-> $stable(addr_o));

endmodule

bind hsa_addresser hsa_addresser_chk #(
   .N(N), .V0(V0), .SCHEME(SCHEME), .ADDR_W(ADDR_W), .V1_FW(V1_FW),
   .TAB_SLOTS(TAB_SLOTS), .INNER_BITS(INNER_BITS), .REG_OUT(REG_OUT)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .x_i    (x_i),
   .addr_o (addr_o),
   .frac_o (frac_o)
);

// File: tb/hsa_addresser_tb.sv
`timescale 1ns/1ps
module hsa_addresser_tb;
   import hsa_pkg::*;

   localparam int N  = 12;
   localparam int V0 = 3;
   localparam int AW = 6;
   localparam logic [63:0] TAB = 64'h2222_2222_2242_0312;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  x = 12'hABC;
   logic [AW-1:0] a_both, a_uni, a_low, a_high;
   logic [N-2:0]  f_both, f_uni, f_low, f_high;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int prev_a [4];
   int prev_f [4];

   always #10 clk = ~clk;

   hsa_addresser #(.N(N), .V0(V0), .SCHEME(HSA_POW2_BOTH), .ADDR_W(AW),
      .INNER_BITS(TAB), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .x_i(x), .addr_o(a_both), .frac_o(f_both));
   hsa_addresser #(.N(N), .V0(V0), .SCHEME(HSA_UNIFORM), .ADDR_W(AW),
      .INNER_BITS(TAB), .REG_OUT(1'b0)) u_dut_uni (
      .clk(clk), .rst_n(rst_n), .x_i(x), .addr_o(a_uni), .frac_o(f_uni));
   hsa_addresser #(.N(N), .V0(V0), .SCHEME(HSA_POW2_LOW), .ADDR_W(AW),
      .INNER_BITS(TAB), .REG_OUT(1'b0)) u_dut_low (
      .clk(clk), .rst_n(rst_n), .x_i(x), .addr_o(a_low), .frac_o(f_low));
   hsa_addresser #(.N(N), .V0(V0), .SCHEME(HSA_POW2_HIGH), .ADDR_W(AW),
      .INNER_BITS(TAB), .REG_OUT(1'b0)) u_dut_high (
      .clk(clk), .rst_n(rst_n), .x_i(x), .addr_o(a_high), .frac_o(f_high));

   function automatic int tab_v1(int j);
      return int'(TAB[j*4 +: 4]);
   endfunction

   // behavioural model: sch 0 uniform, 1 both ends, 2 low end, 3 high end
   function automatic void model(input int sch, input int xv, output int a, output int f);
      int outer, msb, run, j, rem, v1, k, base, z, o;
      outer = xv >> (N - V0);
      msb   = (outer >> (V0 - 1)) & 1;
      run   = 0;
      for (int i = V0 - 1; i >= 0; i--) begin
         if (((outer >> i) & 1) != msb) break;
         run++;
      end
      case (sch)
         0: begin j = outer; rem = N - V0; end
         1: begin
            if (msb == 0) j = (run == V0) ? 0 : V0 - run;
            else          j = (run == V0) ? 2 * V0 - 1 : V0 + run - 1;
            rem = N - 1 - ((run == V0) ? V0 - 1 : run);
         end
         2: begin
            z = msb ? 0 : run;
            j = V0 - z;
            rem = N - 1 - ((z == V0) ? V0 - 1 : z);
         end
         default: begin
            o = msb ? run : 0;
            j = o;
            rem = N - 1 - ((o == V0) ? V0 - 1 : o);
         end
      endcase
      v1 = tab_v1(j);
      base = 0;
      for (int s = 0; s < j; s++) base += 1 << tab_v1(s);
      k = rem - v1;
      a = base + ((xv >> k) & ((1 << v1) - 1));
      f = (xv & ((1 << k) - 1)) << (N - 1 - k);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int dut_a(int s);
      case (s)
         0: return int'(a_uni);
         1: return int'(a_both);
         2: return int'(a_low);
         default: return int'(a_high);
      endcase
   endfunction

   function automatic int dut_f(int s);
      case (s)
         0: return int'(f_uni);
         1: return int'(f_both);
         2: return int'(f_low);
         default: return int'(f_high);
      endcase
   endfunction

   task automatic check_all(input int xv, input bit order);
      int ea, ef;
      string nm [4] = '{"R1 uniform", "R2 R3 both-ends", "R4 low-end", "R5 high-end"};
      for (int s = 0; s < 4; s++) begin
         model(s, xv, ea, ef);
         chk({nm[s], " R6 addr"}, dut_a(s), ea);
         chk({nm[s], " R7 frac"}, dut_f(s), ef);
         if (order) begin
            chk("R9 addr order", int'(dut_a(s) >= prev_a[s]), 1);
            if (dut_a(s) == prev_a[s])
               chk("R9 frac order", int'(dut_f(s) > prev_f[s]), 1);
         end
         prev_a[s] = dut_a(s);
         prev_f[s] = dut_f(s);
      end
   endtask

   task automatic drive(input int xv);
      @(negedge clk);
      x = N'(xv);
      @(negedge clk);
   endtask

   initial begin
      int ea, ef;
      repeat (3) @(negedge clk);
      // R10 registered outputs cleared in reset, combinational ones live
      chk("R10 reset addr", int'(a_both), 0);
      chk("R10 reset frac", int'(f_both), 0);
      model(0, 'hABC, ea, ef);
      chk("R10 comb in reset", int'(a_uni), ea);
      rst_n = 1'b1;

      // R3 directed both-ends points
      drive('h300); chk("R3 both 0x300", int'(a_both), 5);
      chk("R7 both 0x300 frac", int'(f_both), 0);
      drive('h7FF); chk("R3 both 0x7FF", int'(a_both), 13);
      chk("R7 both 0x7FF frac", int'(f_both), 'h7F0);
      drive('hBFF); chk("R3 both 0xBFF", int'(a_both), 14);
      chk("R7 both 0xBFF frac v1=0", int'(f_both), 'h7FE);
      drive('hDFF); chk("R3 both 0xDFF", int'(a_both), 18);
      drive('hFFF); chk("R8 both last", int'(a_both), 34);
      chk("R4 low last", int'(a_low), 14);
      chk("R7 low full frac", int'(f_low), 'h7FF);
      chk("R8 uniform last", int'(a_uni), 42);
      drive('h7FF); chk("R5 high 0x7FF", int'(a_high), 3);
      drive('h000); chk("R8 zero both", int'(a_both), 0);
      chk("R8 zero high", int'(a_high), 0);
      chk("R8 zero frac", int'(f_both), 0);

      // full sweep, one operand per clock
      for (int s = 0; s < 4; s++) begin prev_a[s] = 0; prev_f[s] = -1; end
      for (int v = 0; v < (1 << N); v++) begin
         @(negedge clk);
         if (v > 0) check_all(v - 1, 1'b1);
         x = N'(v);
      end
      @(negedge clk);
      check_all((1 << N) - 1, 1'b1);

      // R10 one-cycle latency of the registered variant
      x = '0;
      #1;
      chk("R10 reg holds old", int'(a_both), 34);
      chk("R10 comb follows", int'(a_uni), 0);
      @(negedge clk);
      chk("R10 reg updated", int'(a_both), 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule